// File: doc/BRIEF.md
# Five-Stage Pipelined Single-Precision Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8-bit biased exponent with bias 127, 23-bit fraction) in a five-deep pipeline. A new operand pair may be presented on every clock. The pair is qualified by a valid bit and carries a caller-chosen tag. The product leaves exactly five clock edges later with the same tag, so a caller can match results to requests without any handshake.

The work is divided into five register stages in a fixed order: the operands are unpacked into sign, exponent and significand, then the significands are multiplied, then the exponents are added and the bias is removed, then the product is normalized, and finally the sign is put back in and the result word is assembled. Normal operands and zero are handled. The fraction is truncated and never rounded. Denormals, infinities and NaNs are not given special meaning, exponent overflow is not detected, and the pipeline has no stall input.

Top module: `fpm_pipe5`

## Requirements
- R1: While reset is asserted, and for the first five clock edges after reset is released internally, `out_vld` is 0.
- R2: A pair accepted (`in_vld`=1) at a rising edge produces `out_vld`=1 with the same tag on `out_tag` after the fifth rising edge that follows, counting the accepting edge as the first.
- R3: Pairs presented on consecutive cycles are all accepted. A burst of N back-to-back pairs yields N consecutive results, and the last result appears N+4 cycles after the first pair is driven, with results in input order.
- R4: A cycle with `in_vld`=0 appears as a cycle with `out_vld`=0 exactly five cycles later. Neighbouring results are not disturbed.
- R5: The result sign (bit 31) is the XOR of the two operand sign bits, for zero results as well.
- R6: For non-zero operands the result exponent field (bits 30:23) is the low 8 bits of ea+eb-127, plus 1 when the significand product has its top bit set. There is no overflow or underflow detection.
- R7: For non-zero operands, the 48-bit product P of the two 24-bit significands (hidden 1 followed by the 23 fraction bits) gives the result fraction as P[46:24] when P[47]=1 and as P[45:23] otherwise. The remaining bits are discarded.
- R8: An operand whose exponent field is 0 counts as zero. If either operand is zero, the result is the computed sign followed by 31 zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operand pair on `op_a`/`op_b` is valid this cycle |
| in_tag | input | TAG_W | Caller tag travelling with the pair |
| op_a | input | 32 | First operand, single-precision format |
| op_b | input | 32 | Second operand, single-precision format |
| out_vld | output | 1 | `out_res`/`out_tag` hold a result this cycle |
| out_tag | output | TAG_W | Tag of the pair whose product is on `out_res` |
| out_res | output | 32 | Product, single-precision format, truncated |

## Verification
The bound checker checks the following on every cycle:
- valid is quiet after reset;
- the valid pattern at the output is the input valid pattern delayed by five cycles;
- the tag and the sign bit of each result match those of the pair accepted five edges earlier;
- a zero operand clears the magnitude bits.

Only the bench scenarios can show that the arithmetic is correct. They compare exponent and truncated fraction values against independently computed products, cover the normalization shift with and without the top product bit, and cover exponent wrap. A measured back-to-back burst shows the N+4 completion time and the unbroken flow of results.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int WORD_W = 32;
  localparam int EW     = 8;
  localparam int FW     = 23;
  localparam int MW     = FW + 1;
  localparam int PW     = 2 * MW;
  localparam int XW     = EW + 2;
  localparam int BIAS   = (1 << (EW - 1)) - 1;
  localparam int STAGES = 5;

  typedef struct packed {
    logic          sign;
    logic          zero;
    logic [EW-1:0] ea;
    logic [EW-1:0] eb;
    logic [MW-1:0] ma;
    logic [MW-1:0] mb;
  } unpk_t;

  typedef struct packed {
    logic          sign;
    logic          zero;
    logic [EW-1:0] ea;
    logic [EW-1:0] eb;
    logic [PW-1:0] prod;
  } prod_t;

  typedef struct packed {
    logic          sign;
    logic          zero;
    logic [XW-1:0] exp;
    logic [PW-1:0] prod;
  } expd_t;

  typedef struct packed {
    logic          sign;
    logic          zero;
    logic [XW-1:0] exp;
    logic [FW-1:0] frac;
  } norm_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output unpk_t             q
);
  unpk_t d;

  always_comb begin
    d.sign = a[WORD_W-1] ^ b[WORD_W-1];
    d.ea   = a[FW +: EW];
    d.eb   = b[FW +: EW];
    d.zero = (a[FW +: EW] == '0) || (b[FW +: EW] == '0);
    d.ma   = {1'b1, a[FW-1:0]};
    d.mb   = {1'b1, b[FW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fpm_mant_mul.sv
module fpm_mant_mul
  import fpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  unpk_t u,
  output prod_t q
);
  prod_t d;

  always_comb begin
    d.sign = u.sign;
    d.zero = u.zero;
    d.ea   = u.ea;
    d.eb   = u.eb;
    d.prod = PW'(u.ma) * PW'(u.mb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fpm_exp_add.sv
module fpm_exp_add
  import fpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  prod_t p,
  output expd_t q
);
  expd_t d;

  always_comb begin
    d.sign = p.sign;
    d.zero = p.zero;
    d.prod = p.prod;
    d.exp  = XW'(p.ea) + XW'(p.eb) - XW'(BIAS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize
  import fpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  expd_t e,
  output norm_t q
);
  norm_t d;

  always_comb begin
    d.sign = e.sign;
    d.zero = e.zero;
    if (e.prod[PW-1]) begin
      d.frac = e.prod[PW-2 -: FW];
      d.exp  = e.exp + XW'(1);
    end else begin
      d.frac = e.prod[PW-3 -: FW];
      d.exp  = e.exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fpm_pipe5.sv
module fpm_pipe5
  import fpm_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              out_vld,
  output logic [TAG_W-1:0]  out_tag,
  output logic [WORD_W-1:0] out_res
);
  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // sideband: valid and tag shift with the data, one slot per stage
  logic [STAGES-1:0] vld_q;
  logic [TAG_W-1:0]  tag_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_side
    logic             v_d;
    logic [TAG_W-1:0] t_d;
    if (g == 0) begin : g_head
      assign v_d = in_vld;
      assign t_d = in_tag;
    end else begin : g_body
      assign v_d = vld_q[g-1];
      assign t_d = tag_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else begin
        vld_q[g] <= v_d;
        if (v_d) tag_q[g] <= t_d;
      end
    end
  end

  // data stages, each clock-enabled by the valid entering it
  unpk_t s1;
  prod_t s2;
  expd_t s3;
  norm_t s4;

  fpm_unpack    i_s1 (.clk(clk), .rst_n(rst_sync_n), .en(in_vld),   .a(op_a), .b(op_b), .q(s1));
  fpm_mant_mul  i_s2 (.clk(clk), .rst_n(rst_sync_n), .en(vld_q[0]), .u(s1), .q(s2));
  fpm_exp_add   i_s3 (.clk(clk), .rst_n(rst_sync_n), .en(vld_q[1]), .p(s2), .q(s3));
  fpm_normalize i_s4 (.clk(clk), .rst_n(rst_sync_n), .en(vld_q[2]), .e(s3), .q(s4));

  // stage 5: sign insertion and word assembly
  logic [WORD_W-1:0] res_d;
  logic [WORD_W-1:0] res_q;

  always_comb begin
    if (s4.zero) res_d = {s4.sign, {(WORD_W-1){1'b0}}};
    else         res_d = {s4.sign, s4.exp[EW-1:0], s4.frac};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   res_q <= '0;
    else if (vld_q[3]) res_q <= res_d;
  end

  assign out_vld = vld_q[STAGES-1];
  assign out_tag = tag_q[STAGES-1];
  assign out_res = res_q;
endmodule

// File: rtl/fpm_pipe5_chk.sv
module fpm_pipe5_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             in_vld,
  input logic [TAG_W-1:0] in_tag,
  input logic [31:0]      op_a,
  input logic [31:0]      op_b,
  input logic             out_vld,
  input logic [TAG_W-1:0] out_tag,
  input logic [31:0]      out_res
);
  // edges seen since internal reset release, saturating at the depth
  logic [2:0] since_rst;
  logic       warm;
  logic       in_zero;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)                 since_rst <= '0;
    else if (since_rst != 3'd5)  since_rst <= since_rst + 3'd1;
  end
  assign warm    = (since_rst == 3'd5);
  assign in_zero = (op_a[30:23] == 8'd0) || (op_b[30:23] == 8'd0);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !warm |-> !out_vld);

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    warm |-> (out_vld == $past(in_vld, 5)));

  assert_tag_follows_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (warm && out_vld) |-> (out_tag == $past(in_tag, 5)));

  assert_sign_xor_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (warm && out_vld) |-> (out_res[31] == $past(op_a[31] ^ op_b[31], 5)));

  assert_zero_operand_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (warm && out_vld && $past(in_zero, 5)) |-> (out_res[30:0] == 31'd0));
endmodule

bind fpm_pipe5 fpm_pipe5_chk #(.TAG_W(TAG_W)) i_chk (
  .clk(clk), .rst_ok(rst_sync_n), .in_vld(in_vld), .in_tag(in_tag),
  .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .out_tag(out_tag), .out_res(out_res)
);

// File: tb/test_fpm_pipe5.sv
module test_fpm_pipe5;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_vld;
  logic [TAG_W-1:0] in_tag;
  logic [31:0]      op_a, op_b;
  logic             out_vld;
  logic [TAG_W-1:0] out_tag;
  logic [31:0]      out_res;

  always #10 clk = ~clk;  // 50 MHz

  fpm_pipe5 #(.TAG_W(TAG_W)) i_fpm_pipe5 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_tag(in_tag),
    .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .out_tag(out_tag), .out_res(out_res)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int first_out, last_out, out_cnt;

  logic             h_vld [5];
  logic [TAG_W-1:0] h_tag [5];
  logic [31:0]      h_res [5];
  string            h_lbl [5];

  // expected product from R5..R8
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic        s;
    logic [47:0] p;
    int          e;
    logic [22:0] f;
    s = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {s, 31'd0};
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin f = p[46:24]; e = e + 1; end
    else       f = p[45:23];
    return {s, e[7:0], f};
  endfunction

  function automatic logic [31:0] rnd_op();
    logic [7:0] ex;
    ex = 8'(64 + ($urandom % 128));
    return {1'($urandom), ex, 23'($urandom)};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string lbl);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", lbl, act, exp, cyc);
    end
  endtask

  task automatic step(input logic v, input logic [TAG_W-1:0] t,
                      input logic [31:0] a, input logic [31:0] b, input string lbl);
    @(negedge clk);
    cyc++;
    // R2 R4: output now reflects the pair driven five negedges ago
    check(32'(out_vld), 32'(h_vld[4]), h_vld[4] ? "R3 valid" : "R4 bubble");
    if (h_vld[4]) begin
      check(32'(out_tag), 32'(h_tag[4]), "R2 tag");
      check(out_res, h_res[4], h_lbl[4]);
    end
    if (out_vld) begin
      if (first_out < 0) first_out = cyc;
      last_out = cyc;
      out_cnt++;
    end
    for (int i = 4; i > 0; i--) begin
      h_vld[i] = h_vld[i-1]; h_tag[i] = h_tag[i-1];
      h_res[i] = h_res[i-1]; h_lbl[i] = h_lbl[i-1];
    end
    h_vld[0] = v; h_tag[0] = t; h_res[0] = ref_mul(a, b); h_lbl[0] = lbl;
    in_vld = v; in_tag = t; op_a = a; op_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 32'd0, 32'd0, "R4 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) begin
      h_vld[i] = 1'b0; h_tag[i] = '0; h_res[i] = '0; h_lbl[i] = "";
    end
    first_out = -1; last_out = -1; out_cnt = 0;
    rst_n = 1'b0; in_vld = 1'b0; in_tag = '0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check(32'(out_vld), 32'd0, "R1 during reset");
    rst_n = 1'b1;
    idle(4);
    check(32'(out_vld), 32'd0, "R1 after release");

    // directed corner cases
    step(1'b1, 4'd1, 32'h3F80_0000, 32'h3F80_0000, "R6 R7 one*one");
    step(1'b1, 4'd2, 32'h3FC0_0000, 32'h3FC0_0000, "R6 R7 normalize shift");
    step(1'b1, 4'd3, 32'hC000_0000, 32'h4040_0000, "R5 negative product");
    step(1'b1, 4'd4, 32'h0000_0000, 32'h4040_0000, "R8 zero a");
    step(1'b1, 4'd5, 32'hBF80_0000, 32'h0012_3456, "R8 R5 zero b signed");
    step(1'b1, 4'd6, 32'h3FFF_FFFF, 32'h3FFF_FFFF, "R7 truncation max mantissa");
    step(1'b0, 4'd0, 32'h0, 32'h0, "R4 bubble");
    step(1'b1, 4'd7, 32'h6480_0000, 32'h6480_0000, "R6 exponent wrap");
    step(1'b1, 4'd8, 32'h1F80_0000, 32'h1F80_0000, "R6 small exponent");
    idle(6);

    // R3: burst of N back-to-back pairs completes in N+4 cycles
    begin
      int start;
      first_out = -1; out_cnt = 0;
      step(1'b1, 4'd0, rnd_op(), rnd_op(), "R3 burst");
      start = cyc;
      for (int i = 1; i < 10; i++) step(1'b1, 4'(i), rnd_op(), rnd_op(), "R3 burst");
      idle(8);
      check(32'(first_out - start), 32'd5, "R2 first latency");
      check(32'(last_out - start), 32'd14, "R3 N+4 completion");
      check(32'(out_cnt), 32'd10, "R3 result count");
    end

    // random mix with bubbles
    for (int i = 0; i < 400; i++) begin
      logic v;
      v = (($urandom % 10) < 7);
      if (($urandom % 16) == 0)
        step(v, 4'($urandom), 32'($urandom) & 32'h807F_FFFF, rnd_op(), "R8 random zero");
      else
        step(v, 4'($urandom), rnd_op(), rnd_op(), "R5 R6 R7 random");
    end
    idle(7);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule